// File: doc/BRIEF.md
# Opcode Pre-Decoder and Length Classifier

This block is a purely combinational decoder for an 8-bit processor opcode. It is given one opcode byte and reports five things about it:

- whether the opcode is defined;
- its addressing mode;
- the total instruction length in bytes;
- its base cycle count;
- whether that mode can take one more cycle when an address crosses a page.

An instruction fetch sequencer uses these outputs. It reads the operand bytes given by the length and plans bus cycles from the base count.

The opcode is split into three fields, written here as aaa (bits 7:5), bbb (bits 4:2) and cc (bits 1:0). The cc field picks a decoding group. Inside that group, bbb picks the addressing mode and aaa picks the operation. A few columns of the opcode map do not follow this pattern, and each of them is handled as an explicit exception. The block does not execute instructions, update flags or add the page-crossing cycle. It only states whether that penalty is possible.

Top module: `opcode_predecoder`

## Requirements
- R1: The mode output uses these codes: 0 implied, 1 accumulator, 2 immediate, 3 zero page, 4 zero page indexed by X, 5 zero page indexed by Y, 6 absolute, 7 absolute indexed by X, 8 absolute indexed by Y, 9 absolute indirect, 10 indexed indirect (zp,X), 11 indirect indexed (zp),Y, 12 relative. In the cc=01 group the bbb field decodes as follows:

  | bbb | mode |
  |-----|------|
  | 000 | (zp,X) |
  | 001 | zero page |
  | 010 | immediate |
  | 011 | absolute |
  | 100 | (zp),Y |
  | 101 | zp,X |
  | 110 | abs,Y |
  | 111 | abs,X |

  Accumulator shifts (low nibble A, opcode below 0x80) report mode 1.
- R2: For a defined opcode the length output is:
  - 1 for implied and accumulator;
  - 2 for immediate, zero page (plain or indexed), relative, (zp,X) and (zp),Y;
  - 3 for absolute (plain or indexed) and absolute indirect.
- R3: Any opcode with cc=11 is reported undefined. These are exactly the opcodes whose low nibble is 3, 7, B or F.
- R4: In the column whose low nibble is 2, only 0xA2 is defined: immediate, 2 bytes, 2 cycles.
- R5: Exactly 151 of the 256 opcode values are reported defined. 0x89 and 0x9E are among the undefined ones.
- R6: Every opcode reports a base cycle count of at least 2. The count for each kind of operation is:

  | Operation | Cycles |
  |-----------|--------|
  | indexed absolute read | 4 |
  | indexed absolute store | 5 |
  | indexed absolute read-modify-write | 7 |
  | (zp),Y read | 5 |
  | (zp),Y store | 6 |
  | (zp,X) | 6 |
  | zero-page read-modify-write | 5 (6 when indexed) |
  | absolute jump | 3 |
  | push | 3 |
  | pull | 4 |
  | return | 6 |
  | branch | 2 |

- R7: The page-penalty output is 1 only for branches and for reads in abs,X, abs,Y or (zp),Y mode. Stores and read-modify-writes in those modes report 0.
- R8: 0x96 and 0xB6 report zero page indexed by Y (mode 5, 4 cycles). 0xBE reports absolute indexed by Y (mode 8) with the page-penalty output set.
- R9: Three opcodes are fixed exceptions:

  | Opcode | Mode | Bytes | Cycles |
  |--------|------|-------|--------|
  | 0x6C | absolute indirect (9) | 3 | 5 |
  | 0x20 | absolute (6) | 3 | 6 |
  | 0x00 | implied (0) | 1 | 7 |

- R10: An undefined opcode reports valid 0, mode 0, length 1, cycles 2 and page-penalty 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opcode_i | input | 8 | Opcode byte to classify |
| valid_o | output | 1 | 1 when the opcode is defined |
| mode_o | output | 4 | Addressing mode code (see R1) |
| length_o | output | LEN_W (2) | Total instruction length in bytes |
| cycles_o | output | CYC_W (3) | Base cycle count, without page or branch penalties |
| may_cross_o | output | 1 | The mode can take one extra cycle on a page crossing |

## Verification
The block holds no state, so a wrong decode appears on the outputs in the same evaluation as the opcode that causes it. Some faults move a single group exception, such as the Y-indexed loads and stores or the lone defined opcode in the low-nibble-2 column. Those show up only as a changed mode or length for that one opcode. A full sweep of all 256 values against an independently built length table, together with a total count of defined opcodes, exposes any slip in validity or length. Spot checks on particular opcodes cover the cycle counts and the page-penalty flag, which the sweep does not pin down.

// File: rtl/opdec_pkg.sv
// Package: shared types and helpers for the opcode pre-decoder.
// Assumes an 8-bit opcode laid out as aaa[7:5] bbb[4:2] cc[1:0].
package opdec_pkg;

    localparam int OPC_W  = 8;
    localparam int FLD_W  = 3;
    localparam int GRP_W  = 2;
    localparam int MODE_W = 4;

    typedef enum logic [MODE_W-1:0] {
        M_IMP = 4'd0,
        M_ACC = 4'd1,
        M_IMM = 4'd2,
        M_ZP  = 4'd3,
        M_ZPX = 4'd4,
        M_ZPY = 4'd5,
        M_ABS = 4'd6,
        M_ABX = 4'd7,
        M_ABY = 4'd8,
        M_IND = 4'd9,
        M_IZX = 4'd10,
        M_IZY = 4'd11,
        M_REL = 4'd12
    } amode_e;

    // Kind of operation; with the mode it fixes the base cycle count.
    typedef enum logic [3:0] {
        K_SIMPLE = 4'd0,
        K_READ   = 4'd1,
        K_WRITE  = 4'd2,
        K_RMW    = 4'd3,
        K_PUSH   = 4'd4,
        K_PULL   = 4'd5,
        K_BRK    = 4'd6,
        K_RET    = 4'd7,
        K_JMP    = 4'd8,
        K_JSR    = 4'd9,
        K_BRANCH = 4'd10
    } kind_e;

    typedef struct packed {
        logic   ok;
        amode_e mode;
        kind_e  kind;
    } grp_res_t;

    localparam grp_res_t GRP_NONE = '{ok: 1'b0, mode: M_IMP, kind: K_SIMPLE};

    // Operation kind for the memory forms of the cc=10 group.
    function automatic kind_e shift_grp_kind(input logic [FLD_W-1:0] aaa);
        case (aaa)
            3'b100:  return K_WRITE;
            3'b101:  return K_READ;
            default: return K_RMW;
        endcase
    endfunction

endpackage

// File: rtl/opdec_grp_alu.sv
// Decoder for the cc=01 group (arithmetic and logic on the accumulator).
// Every bbb value maps to one mode. The only hole is the store with an
// immediate operand (aaa=100, bbb=010).
module opdec_grp_alu
    import opdec_pkg::*;
(
    input  logic [FLD_W-1:0] aaa_i,
    input  logic [FLD_W-1:0] bbb_i,
    output grp_res_t         res_o
);

    // Map the mode field and flag the single undefined slot.
    always_comb begin
        res_o      = GRP_NONE;
        res_o.ok   = !((aaa_i == 3'b100) && (bbb_i == 3'b010));
        res_o.kind = (aaa_i == 3'b100) ? K_WRITE : K_READ;
        case (bbb_i)
            3'b000:  res_o.mode = M_IZX;
            3'b001:  res_o.mode = M_ZP;
            3'b010:  res_o.mode = M_IMM;
            3'b011:  res_o.mode = M_ABS;
            3'b100:  res_o.mode = M_IZY;
            3'b101:  res_o.mode = M_ZPX;
            3'b110:  res_o.mode = M_ABY;
            default: res_o.mode = M_ABX;
        endcase
        if (!res_o.ok) begin
            res_o = GRP_NONE;
        end
    end

endmodule

// File: rtl/opdec_grp_shift.sv
// Decoder for the cc=10 group (shifts, rotates, X loads and stores,
// memory increment and decrement).
// Irregular points:
//   - bbb=000 holds only the X immediate load.
//   - bbb=100 is empty.
//   - bbb=110 holds only the two stack-pointer transfers.
//   - X loads and stores index with Y instead of X.
module opdec_grp_shift
    import opdec_pkg::*;
(
    input  logic [FLD_W-1:0] aaa_i,
    input  logic [FLD_W-1:0] bbb_i,
    output grp_res_t         res_o
);

    logic xreg_op;

    // The X load and store rows (aaa=100/101) swap the index register.
    always_comb xreg_op = (aaa_i[2:1] == 2'b10);

    // Decode mode and kind per column, with the exceptions above.
    always_comb begin
        res_o = GRP_NONE;
        case (bbb_i)
            3'b000: begin
                if (aaa_i == 3'b101) begin
                    res_o = '{ok: 1'b1, mode: M_IMM, kind: K_READ};
                end
            end
            3'b001: res_o = '{ok: 1'b1, mode: M_ZP, kind: shift_grp_kind(aaa_i)};
            3'b010: begin
                if (!aaa_i[2]) begin
                    res_o = '{ok: 1'b1, mode: M_ACC, kind: K_SIMPLE};
                end else begin
                    res_o = '{ok: 1'b1, mode: M_IMP, kind: K_SIMPLE};
                end
            end
            3'b011: res_o = '{ok: 1'b1, mode: M_ABS, kind: shift_grp_kind(aaa_i)};
            3'b101: res_o = '{ok: 1'b1, mode: (xreg_op ? M_ZPY : M_ZPX),
                              kind: shift_grp_kind(aaa_i)};
            3'b110: begin
                if (xreg_op) begin
                    res_o = '{ok: 1'b1, mode: M_IMP, kind: K_SIMPLE};
                end
            end
            3'b111: begin
                if (aaa_i == 3'b101) begin
                    res_o = '{ok: 1'b1, mode: M_ABY, kind: K_READ};
                end else if (aaa_i != 3'b100) begin
                    res_o = '{ok: 1'b1, mode: M_ABX, kind: shift_grp_kind(aaa_i)};
                end
            end
            default: res_o = GRP_NONE;
        endcase
    end

endmodule

// File: rtl/opdec_grp_ctl.sv
// Decoder for the cc=00 group: control flow, stack operations, flag
// operations, Y register and compare forms. This group is the least
// regular, so each column is decoded with its own row table.
module opdec_grp_ctl
    import opdec_pkg::*;
(
    input  logic [FLD_W-1:0] aaa_i,
    input  logic [FLD_W-1:0] bbb_i,
    output grp_res_t         res_o
);

    logic is_store_row;

    // Row aaa=100 holds the Y stores.
    always_comb is_store_row = (aaa_i == 3'b100);

    // Decode each column; the rows without an opcode stay undefined.
    always_comb begin
        res_o = GRP_NONE;
        case (bbb_i)
            3'b000: begin
                case (aaa_i)
                    3'b000:  res_o = '{ok: 1'b1, mode: M_IMP, kind: K_BRK};
                    3'b001:  res_o = '{ok: 1'b1, mode: M_ABS, kind: K_JSR};
                    3'b010,
                    3'b011:  res_o = '{ok: 1'b1, mode: M_IMP, kind: K_RET};
                    3'b100:  res_o = GRP_NONE;
                    default: res_o = '{ok: 1'b1, mode: M_IMM, kind: K_READ};
                endcase
            end
            3'b001: begin
                if (aaa_i == 3'b001 || aaa_i[2]) begin
                    res_o = '{ok: 1'b1, mode: M_ZP,
                              kind: (is_store_row ? K_WRITE : K_READ)};
                end
            end
            3'b010: begin
                case (aaa_i)
                    3'b000,
                    3'b010:  res_o = '{ok: 1'b1, mode: M_IMP, kind: K_PUSH};
                    3'b001,
                    3'b011:  res_o = '{ok: 1'b1, mode: M_IMP, kind: K_PULL};
                    default: res_o = '{ok: 1'b1, mode: M_IMP, kind: K_SIMPLE};
                endcase
            end
            3'b011: begin
                case (aaa_i)
                    3'b000:  res_o = GRP_NONE;
                    3'b010:  res_o = '{ok: 1'b1, mode: M_ABS, kind: K_JMP};
                    3'b011:  res_o = '{ok: 1'b1, mode: M_IND, kind: K_JMP};
                    3'b100:  res_o = '{ok: 1'b1, mode: M_ABS, kind: K_WRITE};
                    default: res_o = '{ok: 1'b1, mode: M_ABS, kind: K_READ};
                endcase
            end
            3'b100: res_o = '{ok: 1'b1, mode: M_REL, kind: K_BRANCH};
            3'b101: begin
                if (aaa_i == 3'b100 || aaa_i == 3'b101) begin
                    res_o = '{ok: 1'b1, mode: M_ZPX,
                              kind: (is_store_row ? K_WRITE : K_READ)};
                end
            end
            3'b110: res_o = '{ok: 1'b1, mode: M_IMP, kind: K_SIMPLE};
            default: begin
                if (aaa_i == 3'b101) begin
                    res_o = '{ok: 1'b1, mode: M_ABX, kind: K_READ};
                end
            end
        endcase
    end

endmodule

// File: rtl/opdec_timing.sv
// Length, base cycle count and page-penalty flag, derived from the mode
// and operation kind. Assumes the group decoders give a consistent mode
// and kind pair. An undefined entry gets the fixed defaults 1 byte,
// 2 cycles and no penalty.
module opdec_timing
    import opdec_pkg::*;
#(
    parameter int LEN_W = 2,
    parameter int CYC_W = 3
) (
    input  logic             ok_i,
    input  amode_e           mode_i,
    input  kind_e            kind_i,
    output logic [LEN_W-1:0] length_o,
    output logic [CYC_W-1:0] cycles_o,
    output logic             may_cross_o
);

    localparam logic [LEN_W-1:0] LEN_ONE   = LEN_W'(1);
    localparam logic [LEN_W-1:0] LEN_TWO   = LEN_W'(2);
    localparam logic [LEN_W-1:0] LEN_THREE = LEN_W'(3);

    // Byte count from the mode alone.
    always_comb begin
        length_o = LEN_ONE;
        if (ok_i) begin
            case (mode_i)
                M_IMP, M_ACC:                  length_o = LEN_ONE;
                M_ABS, M_ABX, M_ABY, M_IND:    length_o = LEN_THREE;
                default:                       length_o = LEN_TWO;
            endcase
        end
    end

    // Base cycle count from the mode and the kind of memory access.
    always_comb begin
        cycles_o = CYC_W'(2);
        if (ok_i) begin
            case (mode_i)
                M_IMP, M_ACC: begin
                    case (kind_i)
                        K_PUSH:  cycles_o = CYC_W'(3);
                        K_PULL:  cycles_o = CYC_W'(4);
                        K_RET:   cycles_o = CYC_W'(6);
                        K_BRK:   cycles_o = CYC_W'(7);
                        default: cycles_o = CYC_W'(2);
                    endcase
                end
                M_ZP:       cycles_o = (kind_i == K_RMW) ? CYC_W'(5) : CYC_W'(3);
                M_ZPX,
                M_ZPY:      cycles_o = (kind_i == K_RMW) ? CYC_W'(6) : CYC_W'(4);
                M_ABS: begin
                    case (kind_i)
                        K_JMP:   cycles_o = CYC_W'(3);
                        K_JSR,
                        K_RMW:   cycles_o = CYC_W'(6);
                        default: cycles_o = CYC_W'(4);
                    endcase
                end
                M_ABX,
                M_ABY: begin
                    case (kind_i)
                        K_RMW:   cycles_o = CYC_W'(7);
                        K_WRITE: cycles_o = CYC_W'(5);
                        default: cycles_o = CYC_W'(4);
                    endcase
                end
                M_IND:      cycles_o = CYC_W'(5);
                M_IZX:      cycles_o = CYC_W'(6);
                M_IZY:      cycles_o = (kind_i == K_READ) ? CYC_W'(5) : CYC_W'(6);
                default:    cycles_o = CYC_W'(2);
            endcase
        end
    end

    // Penalty is possible for branches and for indexed reads only.
    always_comb begin
        may_cross_o = 1'b0;
        if (ok_i) begin
            if (mode_i == M_REL) begin
                may_cross_o = 1'b1;
            end else if (kind_i == K_READ &&
                         (mode_i == M_ABX || mode_i == M_ABY || mode_i == M_IZY)) begin
                may_cross_o = 1'b1;
            end
        end
    end

    // Guard: any three-byte form needs at least three cycles.
    always_comb begin
        if (!$isunknown({ok_i, mode_i, kind_i})) begin
            a_r2_long_form_cycles: assert (length_o != LEN_THREE || cycles_o >= CYC_W'(3))
                else $error("R2: three-byte form with %0d cycles", cycles_o);
        end
    end

endmodule

// File: rtl/opcode_predecoder.sv
// Top of the opcode pre-decoder. Splits the opcode into its fields, runs
// the three group decoders in parallel, picks one by cc, and derives
// length, cycles and page penalty. Purely combinational: there is no clock
// and no reset. cc=11 is entirely undefined.
module opcode_predecoder
    import opdec_pkg::*;
#(
    parameter int LEN_W = 2,
    parameter int CYC_W = 3
) (
    input  logic [OPC_W-1:0]  opcode_i,
    output logic              valid_o,
    output logic [MODE_W-1:0] mode_o,
    output logic [LEN_W-1:0]  length_o,
    output logic [CYC_W-1:0]  cycles_o,
    output logic              may_cross_o
);

    localparam int AAA_LSB = OPC_W - FLD_W;
    localparam int BBB_LSB = GRP_W;

    logic [FLD_W-1:0] aaa;
    logic [FLD_W-1:0] bbb;
    logic [GRP_W-1:0] cc;
    grp_res_t         res_ctl;
    grp_res_t         res_alu;
    grp_res_t         res_shf;
    grp_res_t         sel;

    // Field split of the opcode.
    always_comb begin
        aaa = opcode_i[AAA_LSB +: FLD_W];
        bbb = opcode_i[BBB_LSB +: FLD_W];
        cc  = opcode_i[0 +: GRP_W];
    end

    opdec_grp_ctl u_ctl (
        .aaa_i (aaa),
        .bbb_i (bbb),
        .res_o (res_ctl)
    );

    opdec_grp_alu u_alu (
        .aaa_i (aaa),
        .bbb_i (bbb),
        .res_o (res_alu)
    );

    opdec_grp_shift u_shf (
        .aaa_i (aaa),
        .bbb_i (bbb),
        .res_o (res_shf)
    );

    // Group select; the cc=11 group has no defined opcodes.
    always_comb begin
        case (cc)
            2'b00:   sel = res_ctl;
            2'b01:   sel = res_alu;
            2'b10:   sel = res_shf;
            default: sel = GRP_NONE;
        endcase
    end

    opdec_timing #(
        .LEN_W (LEN_W),
        .CYC_W (CYC_W)
    ) u_tim (
        .ok_i        (sel.ok),
        .mode_i      (sel.mode),
        .kind_i      (sel.kind),
        .length_o    (length_o),
        .cycles_o    (cycles_o),
        .may_cross_o (may_cross_o)
    );

    // Output mapping, with undefined opcodes forced to the implied code.
    always_comb begin
        valid_o = sel.ok;
        mode_o  = sel.ok ? sel.mode : M_IMP;
    end

    // Guards on the port-level behaviour.
    always_comb begin
        if (!$isunknown(opcode_i)) begin
            a_r3_cc11_undefined: assert (cc != 2'b11 || !valid_o)
                else $error("R3: opcode %02h reported defined", opcode_i);
            a_r4_col2_only_a2: assert (opcode_i[3:0] != 4'h2 || opcode_i == 8'hA2 || !valid_o)
                else $error("R4: opcode %02h reported defined", opcode_i);
            a_r6_min_two_cycles: assert (cycles_o >= CYC_W'(2))
                else $error("R6: opcode %02h cycles %0d", opcode_i, cycles_o);
            a_r7_cross_modes: assert (!may_cross_o ||
                                      mode_o == M_ABX || mode_o == M_ABY ||
                                      mode_o == M_IZY || mode_o == M_REL)
                else $error("R7: penalty flag with mode %0d", mode_o);
            a_r10_undef_defaults: assert (valid_o ||
                                          (mode_o == M_IMP && length_o == LEN_W'(1) &&
                                           cycles_o == CYC_W'(2) && !may_cross_o))
                else $error("R10: undefined opcode %02h has non-default outputs", opcode_i);
            a_r2_len_range: assert (length_o >= LEN_W'(1) && length_o <= LEN_W'(3))
                else $error("R2: length %0d out of range", length_o);
        end
    end

endmodule

// File: tb/sim_opcode_predecoder.sv
// Scoreboard bench: the driver applies an opcode and queues the expected
// result. The monitor pops it at the next falling edge and compares.
module sim_opcode_predecoder;

    logic       clk = 1'b0;
    logic [7:0] opcode = 8'hEA;
    logic       valid;
    logic [3:0] mode;
    logic [1:0] length;
    logic [2:0] cycles;
    logic       may_cross;

    int n_checks = 0;
    int n_fail   = 0;
    int n_defined = 0;
    bit done = 1'b0;

    typedef struct {
        logic [7:0] op;
        int         vld;
        int         len;
        int         md;
        int         cyc;
        int         pg;
        int         sweep;
        string      req;
    } exp_t;

    exp_t q[$];

    always #4 clk = ~clk;

    opcode_predecoder u0 (
        .opcode_i    (opcode),
        .valid_o     (valid),
        .mode_o      (mode),
        .length_o    (length),
        .cycles_o    (cycles),
        .may_cross_o (may_cross)
    );

    // Independent length table from the opcode matrix columns; 0 = undefined.
    function automatic int ref_len(input logic [7:0] op);
        logic [3:0] hi;
        logic [3:0] lo;
        hi = op[7:4];
        lo = op[3:0];
        case (lo)
            4'h0: begin
                if (hi == 4'h8) return 0;
                if (hi == 4'h2) return 3;
                if (hi == 4'h0 || hi == 4'h4 || hi == 4'h6) return 1;
                return 2;
            end
            4'h1, 4'h5, 4'h6: return 2;
            4'h2: return (hi == 4'hA) ? 2 : 0;
            4'h4: return (hi inside {4'h2, 4'h8, 4'h9, 4'hA, 4'hB, 4'hC, 4'hE}) ? 2 : 0;
            4'h8: return 1;
            4'h9: begin
                if (hi == 4'h8) return 0;
                return hi[0] ? 3 : 2;
            end
            4'hA: return (hi inside {4'h0, 4'h2, 4'h4, 4'h6, 4'h8, 4'h9,
                                     4'hA, 4'hB, 4'hC, 4'hE}) ? 1 : 0;
            4'hC: return (hi inside {4'h2, 4'h4, 4'h6, 4'h8, 4'hA, 4'hB,
                                     4'hC, 4'hE}) ? 3 : 0;
            4'hD: return 3;
            4'hE: return (hi == 4'h9) ? 0 : 3;
            default: return 0;
        endcase
    endfunction

    task automatic check(input string req, input string what, input logic [7:0] op,
                         input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s op=%02h actual=%0d expected=%0d", req, what, op, act, exp);
        end
    endtask

    // Driver: apply one opcode and queue what it must produce (-1 = skip).
    task automatic send(input logic [7:0] op, input int vld, input int len, input int md,
                        input int cyc, input int pg, input int sweep, input string req);
        exp_t e;
        @(posedge clk);
        #1;
        opcode = op;
        e = '{op: op, vld: vld, len: len, md: md, cyc: cyc, pg: pg, sweep: sweep, req: req};
        q.push_back(e);
    endtask

    // Monitor: compare at the falling edge after each applied opcode.
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            if (e.sweep != 0 && valid) n_defined++;
            check(e.req, "valid", e.op, int'(valid), e.vld);
            if (e.len >= 0) check(e.req, "length", e.op, int'(length), e.len);
            if (e.md  >= 0) check(e.req, "mode",   e.op, int'(mode),   e.md);
            if (e.cyc >= 0) check(e.req, "cycles", e.op, int'(cycles), e.cyc);
            if (e.pg  >= 0) check(e.req, "cross",  e.op, int'(may_cross), e.pg);
            // R6: no opcode reports fewer than two cycles
            n_checks++;
            if (cycles < 3'd2) begin
                n_fail++;
                $display("FAIL R6 min cycles op=%02h actual=%0d expected>=2", e.op, cycles);
            end
        end
    end

    initial begin
        // R10 / startup: first opcode 0xFF (undefined, cc=11, R3)
        send(8'hFF, 0, 1, 0, 2, 0, 0, "R3");
        // R1: cc=01 mode field and accumulator form
        send(8'h09, 1, 2, 2, 2, 0, 0, "R1");
        send(8'h05, 1, 2, 3, 3, 0, 0, "R1");
        send(8'h0D, 1, 3, 6, 4, 0, 0, "R1");
        send(8'h81, 1, 2, 10, 6, 0, 0, "R1");
        send(8'h0A, 1, 1, 1, 2, 0, 0, "R1");
        // R7: penalty only for indexed reads and branches
        send(8'h1D, 1, 3, 7, 4, 1, 0, "R7");
        send(8'hB1, 1, 2, 11, 5, 1, 0, "R7");
        send(8'h9D, 1, 3, 7, 5, 0, 0, "R7");
        send(8'hD0, 1, 2, 12, 2, 1, 0, "R7");
        // R6: cycle counts by kind
        send(8'h91, 1, 2, 11, 6, 0, 0, "R6");
        send(8'hFE, 1, 3, 7, 7, 0, 0, "R6");
        send(8'hE6, 1, 2, 3, 5, 0, 0, "R6");
        send(8'hF6, 1, 2, 4, 6, 0, 0, "R6");
        send(8'h4C, 1, 3, 6, 3, 0, 0, "R6");
        send(8'h48, 1, 1, 0, 3, 0, 0, "R6");
        send(8'h68, 1, 1, 0, 4, 0, 0, "R6");
        send(8'h60, 1, 1, 0, 6, 0, 0, "R6");
        // R8: X loads/stores index with Y
        send(8'h96, 1, 2, 5, 4, 0, 0, "R8");
        send(8'hB6, 1, 2, 5, 4, 0, 0, "R8");
        send(8'hBE, 1, 3, 8, 4, 1, 0, "R8");
        // R9: fixed exceptions
        send(8'h6C, 1, 3, 9, 5, 0, 0, "R9");
        send(8'h20, 1, 3, 6, 6, 0, 0, "R9");
        send(8'h00, 1, 1, 0, 7, 0, 0, "R9");
        // R4: low-nibble-2 column
        send(8'hA2, 1, 2, 2, 2, 0, 0, "R4");
        send(8'h82, 0, 1, 0, 2, 0, 0, "R4");
        // R10: undefined opcodes in regular groups
        send(8'h89, 0, 1, 0, 2, 0, 0, "R10");
        send(8'h9E, 0, 1, 0, 2, 0, 0, "R10");
        // R2 / R5 / R3: full sweep against the column table
        for (int i = 0; i < 256; i++) begin
            int rl;
            rl = ref_len(8'(i));
            if (rl == 0) begin
                send(8'(i), 0, 1, 0, 2, 0, 1, (i[1:0] == 2'b11) ? "R3" : "R5");
            end else begin
                send(8'(i), 1, rl, -1, -1, -1, 1, "R2");
            end
        end
        wait (q.size() == 0);
        @(posedge clk);
        // R5: total of defined opcodes
        check("R5", "defined count", 8'h00, n_defined, 151);
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule